// File: doc/BRIEF.md
# Ten-Bit Target Address Sequencer

This block sits beside a serial I2C target byte engine and adds 10-bit addressing to it. The engine reports bus events as one-cycle pulses: Start, repeated Start, Stop, and a received byte with its value. The sequencer compares each address byte with a single 8-bit compare register owned by the host. It tells the engine whether to acknowledge the byte. It also raises the interrupt, buffer-full and overflow flags, and it reports whether the target is addressed for a write or for a read.

A 10-bit transfer needs the compare register to hold two different values in turn. For the first byte it holds the high pattern `11110 A9 A8 0`. For the second byte it holds the low eight address bits. After each accepted write-direction address byte the sequencer raises an update-address flag and asks the engine to hold SCL low. The host then writes the other half into the compare register. That write clears the flag and releases SCL, so no separate release bit is needed. A read is reached by a repeated Start while the target is addressed for a write, followed by the high byte again with R/W set.

Top module: `tenbit_addr_seq`

## Requirements
- R1: After reset the sequencer is idle, every flag and output pulse is low, and the compare register holds `ADDR_RST` (default 8'hF0). After a Start, byte 8'hF0 is accepted without any host write.
- R2: In the high-byte phase, a byte is accepted when bits [7:3] are 5'b11110, bits [7:1] equal the compare register bits [7:1], bit 0 (R/W) is 0, and buffer-full and overflow are both clear. One cycle after the byte pulse, `ack_vld` and `ack` are 1. In that same cycle `buf_full`, `irq` and `upd_addr` are 1 and `buf_data` holds the byte.
- R3: `scl_hold` is high exactly while `upd_addr` is set. A host write to the compare register loads the value and clears both one cycle later.
- R4: In the low-byte phase, a byte equal to all 8 compare bits is acknowledged. It sets `buf_full`, `irq` and `upd_addr`, and it makes `addressed` 1 with `rd_mode` 0.
- R5: A high byte with R/W=1 is refused (ack_vld=1, ack=0, no flag set) unless a repeated Start occurred while addressed for a write.
- R6: A repeated Start while addressed for a write, followed by a matching high byte with R/W=1, is acknowledged. It sets `irq` and `buf_full`, makes `rd_mode` 1, and leaves `upd_addr` clear.
- R7: A byte that would be accepted but arrives while `buf_full` or `overflow` is set is refused. Overflow and `irq` become 1, `buf_data` and `buf_full` keep their values, and the sequencer goes idle.
- R8: A mismatching address byte, including one whose top five bits are not 11110, is refused and returns the sequencer to idle. Later bytes without a new Start produce no `ack_vld`.
- R9: Stop returns the sequencer to idle from any state, so `addressed` and `rd_mode` are 0 on the next cycle.
- R10: `buf_rd` clears `buf_full`, `irq_clr` clears `irq` and `ovf_clr` clears `overflow`. If a set and a clear occur in the same cycle, the set wins.
- R11: Bytes received while addressed, for data, produce no `ack_vld` and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | Start condition pulse |
| ev_rstart | input | 1 | Repeated Start pulse |
| ev_stop | input | 1 | Stop condition pulse |
| ev_byte | input | 1 | Byte received pulse |
| ev_data | input | 8 | Received byte, valid with ev_byte |
| addr_wr | input | 1 | Host write strobe for the compare register |
| addr_wdata | input | 8 | Host write data |
| buf_rd | input | 1 | Host read of the buffer, clears buf_full |
| irq_clr | input | 1 | Clears irq |
| ovf_clr | input | 1 | Clears overflow |
| ack_vld | output | 1 | Acknowledge decision valid for an address byte |
| ack | output | 1 | 1 = acknowledge, 0 = refuse |
| buf_data | output | 8 | Last accepted address byte |
| buf_full | output | 1 | Buffer-full flag |
| irq | output | 1 | Interrupt flag |
| overflow | output | 1 | Overflow flag |
| upd_addr | output | 1 | Host must rewrite the compare register |
| scl_hold | output | 1 | Request to the engine to keep SCL low |
| rd_mode | output | 1 | Addressed for a read (transmit) |
| addressed | output | 1 | Addressed for either direction |

## Verification
Every result arrives one clock after the input that causes it. This covers the acknowledge decision and all flags after a byte pulse, the state outputs after Start, repeated Start or Stop, and the release of SCL after a host register write. The bench drives each input for exactly one cycle starting at a falling edge. It reads the outputs at the next falling edge, which is the only cycle in which the one-cycle `ack_vld` pulse is visible. Checks for an absent response sample that same cycle, so a late or missing pulse cannot slip past.

// File: rtl/tenbit_addr_seq.sv
module tenbit_addr_seq #(
  parameter int          BYTE_W   = 8,
  parameter logic [7:0]  ADDR_RST = 8'hF0,
  localparam int         TAG_W    = 5,
  localparam logic [4:0] HI_TAG   = 5'b11110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_rstart,
  input  logic              ev_stop,
  input  logic              ev_byte,
  input  logic [BYTE_W-1:0] ev_data,
  input  logic              addr_wr,
  input  logic [BYTE_W-1:0] addr_wdata,
  input  logic              buf_rd,
  input  logic              irq_clr,
  input  logic              ovf_clr,
  output logic              ack_vld,
  output logic              ack,
  output logic [BYTE_W-1:0] buf_data,
  output logic              buf_full,
  output logic              irq,
  output logic              overflow,
  output logic              upd_addr,
  output logic              scl_hold,
  output logic              rd_mode,
  output logic              addressed
);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_HI, S_WAIT_LO, S_ADDR_WR, S_ADDR_RD
  } st_t;

  st_t               st_q, st_d;
  logic              rd_ok_q, rd_ok_d;
  logic [BYTE_W-1:0] cmp_q;
  logic              ua_q, bf_q, irq_q, ovf_q;
  logic              ack_vld_q, ack_q;
  logic [BYTE_W-1:0] buf_q;

  logic hi_hit, lo_hit, want_w, want_r, judge, take, busy, accept, refuse_busy, ua_set;

  assign busy   = bf_q | ovf_q;
  assign hi_hit = (ev_data[BYTE_W-1 -: TAG_W] == HI_TAG) && (ev_data[BYTE_W-1:1] == cmp_q[BYTE_W-1:1]);
  assign lo_hit = (ev_data == cmp_q);
  assign want_w = hi_hit && !ev_data[0];
  assign want_r = hi_hit && ev_data[0] && rd_ok_q;
  assign judge  = ev_byte && (st_q == S_WAIT_HI || st_q == S_WAIT_LO);
  assign take   = judge && ((st_q == S_WAIT_HI) ? (want_w || want_r) : lo_hit);
  assign accept      = take && !busy;
  assign refuse_busy = take && busy;
  assign ua_set      = accept && !(st_q == S_WAIT_HI && ev_data[0]);

  always_comb begin
    st_d    = st_q;
    rd_ok_d = rd_ok_q;
    if (ev_stop) begin
      st_d    = S_IDLE;
      rd_ok_d = 1'b0;
    end else if (ev_start) begin
      st_d    = S_WAIT_HI;
      rd_ok_d = 1'b0;
    end else if (ev_rstart) begin
      st_d    = S_WAIT_HI;
      rd_ok_d = (st_q == S_ADDR_WR);
    end else if (judge) begin
      rd_ok_d = 1'b0;
      if (!accept)                 st_d = S_IDLE;
      else if (st_q == S_WAIT_LO)  st_d = S_ADDR_WR;
      else if (ev_data[0])         st_d = S_ADDR_RD;
      else                         st_d = S_WAIT_LO;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      rd_ok_q   <= 1'b0;
      cmp_q     <= ADDR_RST;
      ua_q      <= 1'b0;
      bf_q      <= 1'b0;
      irq_q     <= 1'b0;
      ovf_q     <= 1'b0;
      ack_vld_q <= 1'b0;
      ack_q     <= 1'b0;
      buf_q     <= '0;
    end else begin
      st_q      <= st_d;
      rd_ok_q   <= rd_ok_d;
      ack_vld_q <= judge;
      ack_q     <= accept;
      if (addr_wr) cmp_q <= addr_wdata;
      if (accept)  buf_q <= ev_data;
      if (ua_set)                     ua_q  <= 1'b1;
      else if (addr_wr)               ua_q  <= 1'b0;
      if (accept)                     bf_q  <= 1'b1;
      else if (buf_rd)                bf_q  <= 1'b0;
      if (accept || refuse_busy)      irq_q <= 1'b1;
      else if (irq_clr)               irq_q <= 1'b0;
      if (refuse_busy)                ovf_q <= 1'b1;
      else if (ovf_clr)               ovf_q <= 1'b0;
    end
  end

  assign ack_vld   = ack_vld_q;
  assign ack       = ack_q;
  assign buf_data  = buf_q;
  assign buf_full  = bf_q;
  assign irq       = irq_q;
  assign overflow  = ovf_q;
  assign upd_addr  = ua_q;
  assign scl_hold  = ua_q;
  assign rd_mode   = (st_q == S_ADDR_RD);
  assign addressed = (st_q == S_ADDR_RD) || (st_q == S_ADDR_WR);

endmodule

// File: rtl/tenbit_addr_seq_chk.sv
module tenbit_addr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_start,
  input logic       ev_rstart,
  input logic       ev_stop,
  input logic       ev_byte,
  input logic [7:0] ev_data,
  input logic       addr_wr,
  input logic       buf_rd,
  input logic       ack_vld,
  input logic       ack,
  input logic       buf_full,
  input logic       overflow,
  input logic       scl_hold,
  input logic       rd_mode,
  input logic       addressed
);

  // R2
  ack_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> $past(ev_byte));

  // R7
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_byte && (buf_full || overflow)) |=> !(ack_vld && ack));

  // R3
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && !ev_byte) |=> !scl_hold);

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!addressed && !rd_mode));

  // R10
  buf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !ev_byte) |=> !buf_full);

  // R6
  read_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_mode) |-> ($past(ev_byte) && $past(ev_data[0])));

  // R11
  data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addressed && ev_byte && !ev_start && !ev_rstart && !ev_stop) |=> !ack_vld);

endmodule

bind tenbit_addr_seq tenbit_addr_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_rstart(ev_rstart),
  .ev_stop(ev_stop), .ev_byte(ev_byte), .ev_data(ev_data), .addr_wr(addr_wr),
  .buf_rd(buf_rd), .ack_vld(ack_vld), .ack(ack), .buf_full(buf_full),
  .overflow(overflow), .scl_hold(scl_hold), .rd_mode(rd_mode), .addressed(addressed)
);

// File: tb/test_tenbit_addr_seq.sv
module test_tenbit_addr_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_start = 0, ev_rstart = 0, ev_stop = 0, ev_byte = 0;
  logic [7:0] ev_data = '0;
  logic addr_wr = 0;
  logic [7:0] addr_wdata = '0;
  logic buf_rd = 0, irq_clr = 0, ovf_clr = 0;
  logic ack_vld, ack, buf_full, irq, overflow, upd_addr, scl_hold, rd_mode, addressed;
  logic [7:0] buf_data;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tenbit_addr_seq i_tenbit_addr_seq (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_rstart(ev_rstart),
    .ev_stop(ev_stop), .ev_byte(ev_byte), .ev_data(ev_data), .addr_wr(addr_wr),
    .addr_wdata(addr_wdata), .buf_rd(buf_rd), .irq_clr(irq_clr), .ovf_clr(ovf_clr),
    .ack_vld(ack_vld), .ack(ack), .buf_data(buf_data), .buf_full(buf_full),
    .irq(irq), .overflow(overflow), .upd_addr(upd_addr), .scl_hold(scl_hold),
    .rd_mode(rd_mode), .addressed(addressed)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_start;   @(negedge clk) ev_start = 1;  @(negedge clk) ev_start = 0;  endtask
  task automatic do_rstart;  @(negedge clk) ev_rstart = 1; @(negedge clk) ev_rstart = 0; endtask
  task automatic do_stop;    @(negedge clk) ev_stop = 1;   @(negedge clk) ev_stop = 0;   endtask
  task automatic do_byte(input logic [7:0] b);
    @(negedge clk) begin ev_byte = 1; ev_data = b; end
    @(negedge clk) ev_byte = 0;
  endtask
  task automatic host_wr(input logic [7:0] v);
    @(negedge clk) begin addr_wr = 1; addr_wdata = v; end
    @(negedge clk) addr_wr = 0;
  endtask
  task automatic clear_all;
    @(negedge clk) begin buf_rd = 1; irq_clr = 1; ovf_clr = 1; end
    @(negedge clk) begin buf_rd = 0; irq_clr = 0; ovf_clr = 0; end
  endtask

  task automatic t_reset;
    check("R1", "ack_vld", ack_vld, 0);
    check("R1", "buf_full", buf_full, 0);
    check("R1", "irq", irq, 0);
    check("R1", "overflow", overflow, 0);
    check("R1", "scl_hold", scl_hold, 0);
    check("R1", "addressed", addressed, 0);
    do_start;
    do_byte(8'hF0);
    check("R1", "ack of reset pattern", {ack_vld, ack}, 2'b11);
    do_stop;
    host_wr(8'hF4);
    clear_all;
  endtask

  task automatic t_write_addr;
    do_start;
    do_byte(8'hF4);
    check("R2", "ack", {ack_vld, ack}, 2'b11);
    check("R2", "flags bf/irq/ua", {buf_full, irq, upd_addr}, 3'b111);
    check("R2", "buf_data", buf_data, 8'hF4);
    check("R3", "scl_hold set", scl_hold, 1);
    host_wr(8'hA5);
    check("R3", "scl_hold released", {scl_hold, upd_addr}, 2'b00);
    clear_all;
    check("R10", "cleared bf/irq", {buf_full, irq}, 2'b00);
    do_byte(8'hA5);
    check("R4", "low ack", {ack_vld, ack}, 2'b11);
    check("R4", "flags bf/irq/ua", {buf_full, irq, upd_addr}, 3'b111);
    check("R4", "addressed/rd_mode", {addressed, rd_mode}, 2'b10);
    host_wr(8'hF4);
    clear_all;
    do_byte(8'h33);
    check("R11", "data byte ack_vld", ack_vld, 0);
    check("R11", "data byte flags", {buf_full, irq, overflow}, 3'b000);
    check("R11", "still addressed", addressed, 1);
  endtask

  task automatic t_read;
    do_rstart;
    check("R6", "addressed after rstart", addressed, 0);
    do_byte(8'hF5);
    check("R6", "read ack", {ack_vld, ack}, 2'b11);
    check("R6", "rd_mode", rd_mode, 1);
    check("R6", "bf/irq/ua", {buf_full, irq, upd_addr}, 3'b110);
    do_stop;
    check("R9", "idle after stop", {addressed, rd_mode}, 2'b00);
    clear_all;
    do_rstart;
    do_byte(8'hF5);
    check("R5", "read refused after rstart from idle", {ack_vld, ack}, 2'b10);
    do_stop;
  endtask

  task automatic t_read_refused;
    do_start;
    do_byte(8'hF5);
    check("R5", "read without write", {ack_vld, ack}, 2'b10);
    check("R5", "no flags", {buf_full, irq, upd_addr}, 3'b000);
    do_byte(8'hA5);
    check("R8", "no response when idle", ack_vld, 0);
  endtask

  task automatic t_mismatch;
    do_start;
    do_byte(8'hF6);
    check("R8", "high mismatch", {ack_vld, ack}, 2'b10);
    do_byte(8'hF4);
    check("R8", "no response after mismatch", ack_vld, 0);
    host_wr(8'h50);
    do_start;
    do_byte(8'h50);
    check("R8", "pattern bits missing", {ack_vld, ack}, 2'b10);
    host_wr(8'hF4);
    do_start;
    do_byte(8'hF4);
    host_wr(8'hA5);
    clear_all;
    do_byte(8'hA4);
    check("R8", "low mismatch", {ack_vld, ack, addressed}, 3'b100);
    host_wr(8'hF4);
    do_stop;
  endtask

  task automatic t_busy;
    do_start;
    do_byte(8'hF4);
    host_wr(8'hA5);
    @(negedge clk) irq_clr = 1;
    @(negedge clk) irq_clr = 0;
    do_byte(8'hA5);
    check("R7", "busy refuse", {ack_vld, ack}, 2'b10);
    check("R7", "ovf/irq/bf", {overflow, irq, buf_full}, 3'b111);
    check("R7", "buf_data kept", buf_data, 8'hF4);
    check("R7", "not addressed", addressed, 0);
    @(negedge clk) ovf_clr = 1;
    @(negedge clk) ovf_clr = 0;
    check("R10", "ovf cleared", overflow, 0);
    @(negedge clk) buf_rd = 1;
    @(negedge clk) buf_rd = 0;
    check("R10", "bf cleared", buf_full, 0);
    host_wr(8'hF4);
    clear_all;
  endtask

  task automatic t_set_wins;
    do_start;
    @(negedge clk) begin ev_byte = 1; ev_data = 8'hF4; buf_rd = 1; irq_clr = 1; end
    @(negedge clk) begin ev_byte = 0; buf_rd = 0; irq_clr = 0; end
    check("R10", "set wins over clear", {buf_full, irq}, 2'b11);
    host_wr(8'hF4);
    do_stop;
    clear_all;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_write_addr;
    t_read;
    t_read_refused;
    t_mismatch;
    t_busy;
    t_set_wins;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule